// File: doc/BRIEF.md
# IPMI Request Dispatcher with Local Capability Reply

This block takes complete IPMI requests from the message reassembler as a byte stream and sorts them into two paths. The first two bytes are held while the block decides. If they are the application request network function (0x18) followed by the interface-capability command (0x57), the block answers by itself. It consumes the rest of the request, builds a short reply and writes that reply into the response buffer. Any other request goes on to the management controller unchanged, byte for byte, with the current 8-bit sequence tag beside it.

Controller responses arrive on their own stream with a tag. A response whose tag matches the current tag is written into the response buffer from address 0, and the tag then advances by one. A response with any other tag is dropped. A response that runs past 255 bytes is cut to 255 bytes, and its completion code at byte 2 is rewritten to mark truncation.

Request FSM states: `S_HDR0` (first byte), `S_HDR1` (second byte), `S_ARG` (argument byte of a local query), `S_DRAIN` (discard the tail of a local query), `S_FLUSH` (replay held bytes to the controller), `S_PASS` (stream the rest to the controller) and `S_LOCAL` (write the local reply). Its transitions are as follows. From `S_HDR0`, a last byte or a byte other than 0x18 goes to `S_FLUSH`; otherwise it goes to `S_HDR1`. From `S_HDR1`, a byte other than 0x57 goes to `S_FLUSH`; a 0x57 that is the last byte goes to `S_LOCAL`; any other 0x57 goes to `S_ARG`. From `S_ARG`, a last byte goes to `S_LOCAL`; otherwise it goes to `S_DRAIN`. From `S_DRAIN`, the last byte goes to `S_LOCAL`. When the held bytes have been replayed, `S_FLUSH` goes to `S_HDR0` if the request has already ended, and to `S_PASS` if it has not. From `S_PASS`, the last byte goes to `S_HDR0`. `S_LOCAL` goes to `S_HDR0` after the final reply byte.

Response FSM states: `R_IDLE`, `R_TAKE` (matched, writing), `R_DROP` (mismatched, discarding) and `R_FIX` (write the truncation code). From `R_IDLE`, a first byte with a matching tag goes to `R_TAKE`, or finishes at once if it is also the last byte. A first byte with a wrong tag goes to `R_DROP`. From `R_TAKE`, the last byte goes to `R_FIX` if 256 or more bytes were seen, and to `R_IDLE` otherwise. `R_FIX` always returns to `R_IDLE`. From `R_DROP`, the last byte goes to `R_IDLE`.

Top module: `ipmi_dispatch`

## Requirements
- R1: A request whose byte 0 is 0x18 and byte 1 is 0x57 produces no byte on the controller stream and causes exactly one buffer completion.
- R2: The local reply's byte 0 is 0x1C and its byte 1 is 0x57.
- R3: A local query only two bytes long gets a 3-byte reply whose byte 2 is 0xC7.
- R4: A local query whose byte 2 has a non-zero low nibble gets a 3-byte reply whose byte 2 is 0xCC.
- R5: Any other local query gets a 7-byte reply: 0x1C, 0x57, 0x00, 0x00, 0x80, 0xFF, 0xFF.
- R6: Every other request appears on the controller stream in the same order with the same bytes. The last flag is set only on the final byte, and the tag equals the current tag.
- R7: A response whose tag equals the current tag is written to buffer addresses 0..N-1 and completes with length N. The current tag then increases by 1, wrapping after 255.
- R8: A response with any other tag causes no buffer write and no completion, and leaves the tag unchanged.
- R9: A response of more than 255 bytes completes with length 255. Buffer bytes 0..254 hold the first 255 response bytes, except byte 2, which holds 0xC6.
- R10: After reset the tag is 0, the request input is ready, and no forward, write or completion is active.
- R11: Bytes after byte 2 of a local query are accepted and discarded; they do not change the reply.
- R12: When a local reply and a matching response overlap, the response is written first, and the local reply follows only after the response has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rq_valid | input | 1 | Request byte valid |
| rq_data | input | 8 | Request byte |
| rq_last | input | 1 | Final byte of the request |
| rq_ready | output | 1 | Request byte accepted this cycle |
| fwd_valid | output | 1 | Byte to the controller valid (controller always takes it) |
| fwd_data | output | 8 | Byte to the controller |
| fwd_last | output | 1 | Final byte of the forwarded request |
| fwd_tag | output | 8 | Current sequence tag |
| ctl_valid | input | 1 | Controller response byte valid |
| ctl_data | input | 8 | Controller response byte |
| ctl_last | input | 1 | Final byte of the response |
| ctl_tag | input | 8 | Tag of the response, held for its whole length |
| buf_we | output | 1 | Response buffer write strobe |
| buf_addr | output | 8 | Response buffer byte address |
| buf_wdata | output | 8 | Response buffer write data |
| buf_done | output | 1 | Response in the buffer is complete |
| buf_len | output | 8 | Length of the completed response |

## Verification
A wrong tag register appears at the ports on the next forwarded byte, through `fwd_tag`. It also appears on the first response that follows: a good response is dropped, or a stale one is accepted, and this shows within the cycles of that response. A request FSM that strays into the wrong path either sends a local query's bytes to the controller or writes a reply for a forwarded request, and this is visible within a few cycles of the request's last byte. An error in the truncation counter shows only at the end of a long response, as a wrong `buf_len` or a missing 0xC6 at address 2.

// File: rtl/ipmi_disp_pkg.sv
package ipmi_disp_pkg;
    localparam int BYTE_W     = 8;
    localparam int MAX_MSG    = 255;
    localparam int TAG_W      = 8;
    localparam int ADDR_W     = $clog2(MAX_MSG + 1);
    localparam int CC_POS     = 2;

    localparam logic [7:0] REQ_NETFN  = 8'h18;
    localparam logic [7:0] RSP_NETFN  = 8'h1C;
    localparam logic [7:0] CMD_CAP    = 8'h57;
    localparam logic [7:0] CC_BADLEN  = 8'hC7;
    localparam logic [7:0] CC_BADFLD  = 8'hCC;
    localparam logic [7:0] CC_TRUNC   = 8'hC6;
    localparam logic [7:0] CAP_FLAGS  = 8'h80;

    typedef enum logic [1:0] {REP_OK, REP_BADLEN, REP_BADFLD} rep_kind_t;

    function automatic logic [7:0] rep_len(input rep_kind_t k);
        return (k == REP_OK) ? 8'd7 : 8'd3;
    endfunction

    function automatic logic [7:0] rep_byte(input rep_kind_t k, input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = RSP_NETFN;
            3'd1:    b = CMD_CAP;
            3'd2:    b = (k == REP_BADLEN) ? CC_BADLEN :
                         (k == REP_BADFLD) ? CC_BADFLD : 8'h00;
            3'd3:    b = 8'h00;
            3'd4:    b = CAP_FLAGS;
            default: b = 8'(MAX_MSG);
        endcase
        return b;
    endfunction
endpackage

// File: rtl/ipmi_req_sorter.sv
module ipmi_req_sorter
    import ipmi_disp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rq_valid,
    input  logic [BYTE_W-1:0] rq_data,
    input  logic              rq_last,
    output logic              rq_ready,
    output logic              fwd_valid,
    output logic [BYTE_W-1:0] fwd_data,
    output logic              fwd_last,
    input  logic              loc_grant,
    output logic              loc_we,
    output logic [2:0]        loc_idx,
    output logic [BYTE_W-1:0] loc_data,
    output logic              loc_done,
    output logic [BYTE_W-1:0] loc_len
);
    typedef enum logic [2:0] {
        S_HDR0, S_HDR1, S_ARG, S_DRAIN, S_FLUSH, S_PASS, S_LOCAL
    } req_st_t;

    req_st_t           st, st_nx;
    logic [BYTE_W-1:0] h0, h1;
    logic              two_held, ended, fsel;
    rep_kind_t         kind;
    logic [2:0]        lidx;
    logic              take, flush_end;

    assign take      = rq_valid && rq_ready;
    assign flush_end = !two_held || fsel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_HDR0;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h0 <= '0; h1 <= '0; two_held <= 1'b0; ended <= 1'b0;
            fsel <= 1'b0; kind <= REP_OK; lidx <= '0;
        end else begin
            case (st)
                S_HDR0: if (take) begin
                    h0 <= rq_data; two_held <= 1'b0; ended <= rq_last;
                    fsel <= 1'b0; lidx <= '0;
                end
                S_HDR1: if (take) begin
                    h1 <= rq_data; two_held <= 1'b1; ended <= rq_last;
                    if (rq_last) kind <= REP_BADLEN;
                end
                S_ARG: if (take)
                    kind <= (rq_data[3:0] != 4'h0) ? REP_BADFLD : REP_OK;
                S_FLUSH: fsel <= 1'b1;
                S_LOCAL: if (loc_grant) lidx <= lidx + 3'd1;
                default: ;
            endcase
        end
    end

    always_comb begin
        st_nx     = st;
        rq_ready  = 1'b0;
        fwd_valid = 1'b0;
        fwd_data  = '0;
        fwd_last  = 1'b0;
        loc_we    = 1'b0;
        loc_done  = 1'b0;
        loc_idx   = lidx;
        loc_data  = rep_byte(kind, lidx);
        loc_len   = rep_len(kind);
        unique case (st)
            S_HDR0: begin
                rq_ready = 1'b1;
                if (rq_valid)
                    st_nx = (rq_data != REQ_NETFN || rq_last) ? S_FLUSH : S_HDR1;
            end
            S_HDR1: begin
                rq_ready = 1'b1;
                if (rq_valid) begin
                    if (rq_data != CMD_CAP) st_nx = S_FLUSH;
                    else                    st_nx = rq_last ? S_LOCAL : S_ARG;
                end
            end
            S_ARG: begin
                rq_ready = 1'b1;
                if (rq_valid) st_nx = rq_last ? S_LOCAL : S_DRAIN;
            end
            S_DRAIN: begin
                rq_ready = 1'b1;
                if (rq_valid && rq_last) st_nx = S_LOCAL;
            end
            S_FLUSH: begin
                fwd_valid = 1'b1;
                fwd_data  = fsel ? h1 : h0;
                fwd_last  = ended && flush_end;
                if (flush_end) st_nx = ended ? S_HDR0 : S_PASS;
            end
            S_PASS: begin
                rq_ready  = 1'b1;
                fwd_valid = rq_valid;
                fwd_data  = rq_data;
                fwd_last  = rq_last;
                if (rq_valid && rq_last) st_nx = S_HDR0;
            end
            S_LOCAL: begin
                loc_we = loc_grant;
                if (loc_grant && ({5'd0, lidx} == loc_len - 8'd1)) begin
                    loc_done = 1'b1;
                    st_nx    = S_HDR0;
                end
            end
            default: st_nx = S_HDR0;
        endcase
    end
endmodule

// File: rtl/ipmi_rsp_loader.sv
module ipmi_rsp_loader
    import ipmi_disp_pkg::*;
#(
    parameter int MSG_MAX = MAX_MSG,
    parameter int TW      = TAG_W,
    parameter int AW      = $clog2(MSG_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_valid,
    input  logic [BYTE_W-1:0] ctl_data,
    input  logic              ctl_last,
    input  logic [TW-1:0]     ctl_tag,
    output logic [TW-1:0]     cur_tag,
    output logic              busy,
    output logic              rsp_we,
    output logic [AW-1:0]     rsp_addr,
    output logic [BYTE_W-1:0] rsp_data,
    output logic              rsp_done,
    output logic [AW-1:0]     rsp_len
);
    typedef enum logic [1:0] {R_IDLE, R_TAKE, R_DROP, R_FIX} rsp_st_t;

    localparam logic [AW-1:0] LIMIT = AW'(MSG_MAX);

    rsp_st_t       st, st_nx;
    logic [AW-1:0] cnt;
    logic [TW-1:0] tag;

    assign cur_tag = tag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= R_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            tag <= '0;
        end else begin
            if (st == R_IDLE && ctl_valid)      cnt <= AW'(1);
            else if (st == R_TAKE && ctl_valid) cnt <= (cnt == LIMIT) ? cnt : cnt + AW'(1);
            if (rsp_done) tag <= tag + TW'(1);
        end
    end

    always_comb begin
        st_nx    = st;
        busy     = (st != R_IDLE) || ctl_valid;
        rsp_we   = 1'b0;
        rsp_addr = cnt;
        rsp_data = ctl_data;
        rsp_done = 1'b0;
        rsp_len  = cnt + AW'(1);
        unique case (st)
            R_IDLE: if (ctl_valid) begin
                if (ctl_tag == tag) begin
                    rsp_we   = 1'b1;
                    rsp_addr = '0;
                    rsp_len  = AW'(1);
                    if (ctl_last) rsp_done = 1'b1;
                    else          st_nx    = R_TAKE;
                end else if (!ctl_last) begin
                    st_nx = R_DROP;
                end
            end
            R_TAKE: if (ctl_valid) begin
                rsp_we = (cnt < LIMIT);
                if (ctl_last) begin
                    if (cnt >= LIMIT) st_nx = R_FIX;
                    else begin
                        rsp_done = 1'b1;
                        st_nx    = R_IDLE;
                    end
                end
            end
            R_FIX: begin
                rsp_we   = 1'b1;
                rsp_addr = AW'(CC_POS);
                rsp_data = CC_TRUNC;
                rsp_done = 1'b1;
                rsp_len  = LIMIT;
                st_nx    = R_IDLE;
            end
            R_DROP: if (ctl_valid && ctl_last) st_nx = R_IDLE;
            default: st_nx = R_IDLE;
        endcase
    end
endmodule

// File: rtl/ipmi_dispatch.sv
module ipmi_dispatch
    import ipmi_disp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rq_valid,
    input  logic [7:0]        rq_data,
    input  logic              rq_last,
    output logic              rq_ready,
    output logic              fwd_valid,
    output logic [7:0]        fwd_data,
    output logic              fwd_last,
    output logic [7:0]        fwd_tag,
    input  logic              ctl_valid,
    input  logic [7:0]        ctl_data,
    input  logic              ctl_last,
    input  logic [7:0]        ctl_tag,
    output logic              buf_we,
    output logic [7:0]        buf_addr,
    output logic [7:0]        buf_wdata,
    output logic              buf_done,
    output logic [7:0]        buf_len
);
    logic              rsp_busy, rsp_we, rsp_done;
    logic [ADDR_W-1:0] rsp_addr, rsp_len;
    logic [BYTE_W-1:0] rsp_data;
    logic              loc_we, loc_done;
    logic [2:0]        loc_idx;
    logic [BYTE_W-1:0] loc_data, loc_len;

    ipmi_req_sorter u_req (
        .clk(clk), .rst_n(rst_n),
        .rq_valid(rq_valid), .rq_data(rq_data), .rq_last(rq_last), .rq_ready(rq_ready),
        .fwd_valid(fwd_valid), .fwd_data(fwd_data), .fwd_last(fwd_last),
        .loc_grant(!rsp_busy),
        .loc_we(loc_we), .loc_idx(loc_idx), .loc_data(loc_data),
        .loc_done(loc_done), .loc_len(loc_len)
    );

    ipmi_rsp_loader #(.MSG_MAX(MAX_MSG), .TW(TAG_W), .AW(ADDR_W)) u_rsp (
        .clk(clk), .rst_n(rst_n),
        .ctl_valid(ctl_valid), .ctl_data(ctl_data), .ctl_last(ctl_last), .ctl_tag(ctl_tag),
        .cur_tag(fwd_tag), .busy(rsp_busy),
        .rsp_we(rsp_we), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
        .rsp_done(rsp_done), .rsp_len(rsp_len)
    );

    always_comb begin
        buf_we    = rsp_we | loc_we;
        buf_addr  = rsp_we ? 8'(rsp_addr) : 8'(loc_idx);
        buf_wdata = rsp_we ? rsp_data : loc_data;
        buf_done  = rsp_done | loc_done;
        buf_len   = rsp_done ? 8'(rsp_len) : loc_len;
    end
endmodule

// File: rtl/ipmi_dispatch_chk.sv
module ipmi_dispatch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       buf_we,
    input logic [7:0] buf_addr,
    input logic [7:0] fwd_tag,
    input logic       rsp_we,
    input logic       rsp_done,
    input logic       loc_we
);
    // R12: the two writers never drive the buffer together
    a_r12_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_we && loc_we));

    // R7: an accepted response advances the tag by one
    a_r7_tag_advance: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> (fwd_tag == $past(fwd_tag) + 8'd1));

    // R8: without an accepted response the tag holds
    a_r8_tag_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_done |=> $stable(fwd_tag));

    // R9: no write reaches past the last legal buffer byte
    a_r9_addr_cap: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (buf_addr < 8'd255));
endmodule

bind ipmi_dispatch ipmi_dispatch_chk u_chk (
    .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_addr(buf_addr),
    .fwd_tag(fwd_tag), .rsp_we(rsp_we), .rsp_done(rsp_done), .loc_we(loc_we)
);

// File: tb/test_ipmi_dispatch.sv
module test_ipmi_dispatch;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rq_valid = 1'b0, rq_last = 1'b0, rq_ready;
    logic [7:0] rq_data = '0;
    logic fwd_valid, fwd_last;
    logic [7:0] fwd_data, fwd_tag;
    logic ctl_valid = 1'b0, ctl_last = 1'b0;
    logic [7:0] ctl_data = '0, ctl_tag = '0;
    logic buf_we, buf_done;
    logic [7:0] buf_addr, buf_wdata, buf_len;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipmi_dispatch i_ipmi_dispatch (
        .clk(clk), .rst_n(rst_n),
        .rq_valid(rq_valid), .rq_data(rq_data), .rq_last(rq_last), .rq_ready(rq_ready),
        .fwd_valid(fwd_valid), .fwd_data(fwd_data), .fwd_last(fwd_last), .fwd_tag(fwd_tag),
        .ctl_valid(ctl_valid), .ctl_data(ctl_data), .ctl_last(ctl_last), .ctl_tag(ctl_tag),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .buf_done(buf_done), .buf_len(buf_len)
    );

    int checks = 0, fails = 0, wcnt = 0, dcnt = 0, dlen = 0;
    logic [7:0] mem [256];
    logic [7:0] fq[$];
    logic       fl[$];
    logic [7:0] ftg[$];
    logic [7:0] msg[$];
    logic [7:0] exp_tag = 8'd0;

    always @(negedge clk) if (rst_n) begin
        if (buf_we)    begin mem[buf_addr] = buf_wdata; wcnt++; end
        if (buf_done)  begin dcnt++; dlen = buf_len; end
        if (fwd_valid) begin fq.push_back(fwd_data); fl.push_back(fwd_last); ftg.push_back(fwd_tag); end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] local_exp(input int kind, input int i);
        logic [7:0] r [7];
        r = '{8'h1C, 8'h57, 8'h00, 8'h00, 8'h80, 8'hFF, 8'hFF};
        if (i == 2 && kind == 1) return 8'hCC;
        if (i == 2 && kind == 2) return 8'hC7;
        return r[i];
    endfunction

    function automatic logic [7:0] rsp_byte(input logic [7:0] seed, input int i);
        return 8'(i * 7) ^ seed;
    endfunction

    task automatic send_req();
        for (int i = 0; i < msg.size(); i++) begin
            rq_valid = 1'b1; rq_data = msg[i]; rq_last = (i == msg.size() - 1);
            @(negedge clk);
            while (!rq_ready) @(negedge clk);
            @(posedge clk); #1;
        end
        rq_valid = 1'b0; rq_last = 1'b0;
    endtask

    task automatic send_rsp(input int len, input logic [7:0] tag, input logic [7:0] seed);
        for (int i = 0; i < len; i++) begin
            ctl_valid = 1'b1; ctl_data = rsp_byte(seed, i);
            ctl_last = (i == len - 1); ctl_tag = tag;
            @(posedge clk); #1;
        end
        ctl_valid = 1'b0; ctl_last = 1'b0;
    endtask

    task automatic check_local(input int kind, input int d0, input int f0, input bit extra);
        int n;
        n = (kind == 0) ? 7 : 3;
        chk(dcnt == d0 + 1, "R1 one completion", dcnt - d0, 1);
        chk(fq.size() == f0, extra ? "R11 tail not forwarded" : "R1 nothing forwarded", fq.size(), f0);
        chk(dlen == n, kind == 0 ? "R5 length" : (kind == 1 ? "R4 length" : "R3 length"), dlen, n);
        for (int i = 0; i < n; i++)
            chk(mem[i] == local_exp(kind, i),
                i < 2 ? "R2 header" : (kind == 0 ? "R5 body" : (kind == 1 ? "R4 code" : "R3 code")),
                mem[i], local_exp(kind, i));
    endtask

    task automatic run_local(input int kind, input int extra);
        int d0, f0;
        d0 = dcnt; f0 = fq.size();
        msg = {8'h18, 8'h57};
        if (kind == 0) msg.push_back(8'($urandom_range(0, 15)) << 4);
        if (kind == 1) msg.push_back({4'($urandom_range(0, 15)), 4'($urandom_range(1, 15))});
        if (kind != 2) for (int i = 0; i < extra; i++) msg.push_back(8'($urandom));
        send_req();
        repeat (12) @(posedge clk); #1;
        check_local(kind, d0, f0, extra > 0);
    endtask

    task automatic run_fwd(input int len, input bit hdr);
        fq.delete(); fl.delete(); ftg.delete();
        msg.delete();
        for (int i = 0; i < len; i++) msg.push_back(8'($urandom));
        if (hdr) msg[0] = 8'h18;
        if (len > 1 && msg[0] == 8'h18 && msg[1] == 8'h57) msg[1] = 8'h56;
        send_req();
        repeat (3) @(posedge clk); #1;
        chk(fq.size() == len, "R6 forwarded count", fq.size(), len);
        for (int i = 0; i < len && i < fq.size(); i++) begin
            chk(fq[i] == msg[i], "R6 forwarded byte", fq[i], msg[i]);
            chk(fl[i] == (i == len - 1), "R6 last flag", fl[i], i == len - 1);
            chk(ftg[i] == exp_tag, "R6 tag", ftg[i], exp_tag);
        end
    endtask

    task automatic run_rsp(input int len, input bit good);
        int d0, w0, n;
        logic [7:0] seed, tag, e;
        d0 = dcnt; w0 = wcnt; seed = 8'($urandom);
        tag = good ? exp_tag : exp_tag + 8'($urandom_range(1, 255));
        send_rsp(len, tag, seed);
        repeat (3) @(posedge clk); #1;
        if (good) begin
            n = (len > 255) ? 255 : len;
            exp_tag = exp_tag + 8'd1;
            chk(dcnt == d0 + 1, "R7 completion", dcnt - d0, 1);
            chk(dlen == n, len > 255 ? "R9 length" : "R7 length", dlen, n);
            for (int i = 0; i < n; i++) begin
                e = (len > 255 && i == 2) ? 8'hC6 : rsp_byte(seed, i);
                chk(mem[i] == e, len > 255 ? "R9 byte" : "R7 byte", mem[i], e);
            end
            chk(fwd_tag == exp_tag, "R7 tag advance", fwd_tag, exp_tag);
        end else begin
            chk(wcnt == w0, "R8 no writes", wcnt - w0, 0);
            chk(dcnt == d0, "R8 no completion", dcnt - d0, 0);
            chk(fwd_tag == exp_tag, "R8 tag held", fwd_tag, exp_tag);
        end
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int d0;
        logic [7:0] seed;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(fwd_tag == 8'd0, "R10 tag", fwd_tag, 0);
        chk(rq_ready == 1'b1, "R10 ready", rq_ready, 1);
        chk(!fwd_valid && !buf_we && !buf_done, "R10 quiet", {fwd_valid, buf_we, buf_done}, 0);
        @(posedge clk); #1;

        run_local(0, 0);
        run_local(0, 4);
        run_local(1, 0);
        run_local(2, 0);
        run_fwd(1, 1'b1);
        run_rsp(1, 1'b1);
        run_fwd(2, 1'b1);
        run_rsp(255, 1'b1);
        run_fwd(5, 1'b0);
        run_rsp(256, 1'b1);
        run_fwd(3, 1'b1);
        run_rsp(300, 1'b1);
        run_rsp(20, 1'b0);

        // R12: local reply overlapping a matching response
        d0 = dcnt; seed = 8'h3C;
        msg = {8'h18, 8'h57, 8'h00};
        fork
            send_req();
            send_rsp(20, exp_tag, seed);
        join
        repeat (12) @(posedge clk); #1;
        exp_tag = exp_tag + 8'd1;
        chk(dcnt == d0 + 2, "R12 two completions", dcnt - d0, 2);
        chk(dlen == 7, "R12 local last", dlen, 7);
        for (int i = 0; i < 7; i++)
            chk(mem[i] == local_exp(0, i), "R12 local bytes", mem[i], local_exp(0, i));
        for (int i = 7; i < 20; i++)
            chk(mem[i] == rsp_byte(seed, i), "R12 response tail", mem[i], rsp_byte(seed, i));

        for (int it = 0; it < 60; it++) begin
            case ($urandom_range(0, 4))
                0: run_local(0, $urandom_range(0, 3));
                1: run_local(1, $urandom_range(0, 2));
                2: run_local(2, 0);
                default: begin
                    run_fwd($urandom_range(1, 8), 1'($urandom_range(0, 1)));
                    run_rsp($urandom_range(1, 40), $urandom_range(0, 3) != 0);
                end
            endcase
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule